// File: doc/BRIEF.md
# Descriptor-driven bus-master DMA engine

This block is the bus-master data mover for one channel of a disk interface. Software builds a table of descriptors in memory, writes the table's start address into a pointer register, clears stale status, and then writes the command register with a direction and a start bit. The engine walks the table entry by entry. For each entry it fetches the buffer address and byte count, then moves whole 32-bit words between that buffer and a device-side data FIFO. It stops after the entry that carries the end-of-table flag.

Completion and failure are reported in a status register. Its error and interrupt bits are cleared by writing ones. A transfer is good when, once the engine has gone idle, the interrupt bit is set and the error bit is clear. The interrupt bit also drives a level interrupt output. Software aborts a transfer by writing zero to the command register. When two channels are built, each gets its own instance. The second channel's register window is placed at a fixed offset above the first one by the surrounding address decoder.

Top module: `bmdma_engine`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and no memory request or device handshake is driven.
- R2: Register map, selected by `reg_addr_i`:
  - Offset 0 is the command register: bit 0 is start, bit 3 is direction, and 1 means device-to-memory.
  - Offset 1 is the status register: bit 0 is active (read-only), bit 1 is error, bit 2 is interrupt, and bits 5 and 6 are capability flags.
  - Offset 2 is the 32-bit table pointer, whose bits 1:0 always read zero.
- R3: A descriptor is two words at the table pointer, and the entries follow at an 8-byte stride, processed in order.
  - Word 0 is the buffer address, with bits 1:0 ignored.
  - Word 1 holds the end-of-table flag in bit 31 and the byte count in bits 15:0. Count bits 1:0 are ignored, so the count is rounded down to whole words.
- R4: With direction 0, the buffer words are presented on the device write port in ascending address order. Each word is held stable until `dev_wr_ready_i` accepts it.
- R5: With direction 1, the words accepted from the device read port are written to consecutive ascending buffer addresses.
- R6: When the last word of the end-of-table entry completes, active clears and the interrupt bit sets in the same cycle. The error bit stays clear, and `irq_o` follows the interrupt bit.
- R7: An entry whose word count is zero moves no data. The engine proceeds to the next entry, or completes if that entry ends the table.
- R8: An error response on any memory access sets the error bit and clears active. After it the engine issues no further request and leaves the interrupt bit clear.
- R9: Writing the status register with a one in bit 1 or bit 2 clears that bit, and a zero leaves it unchanged. A set by the engine in the same cycle wins.
- R10: The capability bits are read/write storage and have no effect on a transfer.
- R11: A command write with start at 0 stops the engine: active is clear in the next cycle, no further request follows, and error and interrupt are left unchanged.
- R12: A command write with start at 1 while active is ignored. The command register and the running transfer are unchanged.
- R13: A memory request keeps its address, write enable and write data stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt level, equals the status interrupt bit |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory response for the pending request |
| mem_err_i | input | 1 | Response is an error, valid with `mem_ack_i` |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |
| dev_wr_valid_o | output | 1 | Word offered to the device FIFO |
| dev_wr_data_o | output | 32 | Word to the device |
| dev_wr_ready_i | input | 1 | Device FIFO accepts the word |
| dev_rd_valid_i | input | 1 | Device FIFO offers a word |
| dev_rd_data_i | input | 32 | Word from the device |
| dev_rd_ready_o | output | 1 | Engine takes the offered word |

## Verification
The assertions assume that memory raises `mem_ack_i` only while `mem_req_o` is high. They also assume each response arrives at least one cycle after the request appears, and that `mem_err_i` is meaningful only together with an acknowledge. The bench memory model enforces this: it answers one request at a time and never acknowledges twice in a row, and a fixed cycle pattern inserts stall cycles so that requests are held. The device sink drops its ready signal on alternate cycles, or on three cycles out of four, so that held words are seen. The source offers data only from its prepared list. Stops and ignored starts are issued through the register port at cycles where a request or a device word is pending.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned RA_W = 2;

  localparam logic [RA_W-1:0] REG_CMD  = 2'd0;
  localparam logic [RA_W-1:0] REG_STAT = 2'd1;
  localparam logic [RA_W-1:0] REG_PTR  = 2'd2;

  localparam int unsigned CMD_GO   = 0;
  localparam int unsigned CMD_DIR  = 3;
  localparam int unsigned STA_ACT  = 0;
  localparam int unsigned STA_ERR  = 1;
  localparam int unsigned STA_IRQ  = 2;
  localparam int unsigned STA_CAP0 = 5;
  localparam int unsigned STA_CAP1 = 6;
  localparam int unsigned DESC_EOT = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC_BASE,
    ST_DESC_CNT,
    ST_MEM_RD,
    ST_DEV_PUSH,
    ST_DEV_POP,
    ST_MEM_WR,
    ST_NEXT
  } seq_state_e;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              active_i,
  input  logic              done_i,
  input  logic              fault_i,
  output logic              go_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] tbl_ptr_o,
  output logic              err_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(DW / 8 - 1);

  logic              cmd_go_q, cmd_dir_q, err_q, irq_q;
  logic [1:0]        cap_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              cmd_wr, stat_wr, ptr_wr, cmd_take;

  assign cmd_wr   = reg_we_i && (reg_addr_i == REG_CMD);
  assign stat_wr  = reg_we_i && (reg_addr_i == REG_STAT);
  assign ptr_wr   = reg_we_i && (reg_addr_i == REG_PTR);
  // start while running is dropped entirely
  assign cmd_take = cmd_wr && !(reg_wdata_i[CMD_GO] && active_i);
  assign go_o     = cmd_wr && reg_wdata_i[CMD_GO] && !active_i;
  assign stop_o   = cmd_wr && !reg_wdata_i[CMD_GO];
  assign dir_o    = reg_wdata_i[CMD_DIR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_go_q  <= 1'b0;
      cmd_dir_q <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
      cap_q     <= '0;
      ptr_q     <= '0;
    end else begin
      if (cmd_take) begin
        cmd_go_q  <= reg_wdata_i[CMD_GO];
        cmd_dir_q <= reg_wdata_i[CMD_DIR];
      end
      err_q <= fault_i | (err_q & ~(stat_wr & reg_wdata_i[STA_ERR]));
      irq_q <= done_i  | (irq_q & ~(stat_wr & reg_wdata_i[STA_IRQ]));
      if (stat_wr) cap_q <= {reg_wdata_i[STA_CAP1], reg_wdata_i[STA_CAP0]};
      if (ptr_wr) ptr_q <= ADDR_W'(reg_wdata_i) & ALIGN;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CMD: begin
        reg_rdata_o[CMD_GO]  = cmd_go_q;
        reg_rdata_o[CMD_DIR] = cmd_dir_q;
      end
      REG_STAT: begin
        reg_rdata_o[STA_ACT]  = active_i;
        reg_rdata_o[STA_ERR]  = err_q;
        reg_rdata_o[STA_IRQ]  = irq_q;
        reg_rdata_o[STA_CAP0] = cap_q[0];
        reg_rdata_o[STA_CAP1] = cap_q[1];
      end
      REG_PTR: reg_rdata_o = DW'(ptr_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign tbl_ptr_o = ptr_q;
  assign err_o     = err_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              stop_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] tbl_ptr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              dev_wr_valid_o,
  output logic [DW-1:0]     dev_wr_data_o,
  input  logic              dev_wr_ready_i,
  input  logic              dev_rd_valid_i,
  input  logic [DW-1:0]     dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              active_o,
  output logic              done_o,
  output logic              fault_o
);
  localparam int unsigned       BYTES    = DW / 8;
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(BYTES);
  localparam logic [ADDR_W-1:0] A_STRIDE = ADDR_W'(2 * BYTES);
  localparam logic [ADDR_W-1:0] A_ALIGN  = ~(A_STEP - 1'b1);
  localparam logic [CNT_W-1:0]  C_STEP   = CNT_W'(BYTES);
  localparam logic [CNT_W-1:0]  C_MASK   = ~(C_STEP - 1'b1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] desc_q, addr_q;
  logic [CNT_W-1:0]  remain_q, cnt_in;
  logic [DW-1:0]     data_q;
  logic              eot_q, dir_q;
  logic              ack_ok, ack_bad, last_word;

  assign mem_req_o = (state_q == ST_DESC_BASE) || (state_q == ST_DESC_CNT) ||
                     (state_q == ST_MEM_RD)    || (state_q == ST_MEM_WR);
  assign mem_we_o       = (state_q == ST_MEM_WR);
  assign mem_wdata_o    = data_q;
  assign dev_wr_valid_o = (state_q == ST_DEV_PUSH);
  assign dev_wr_data_o  = data_q;
  assign dev_rd_ready_o = (state_q == ST_DEV_POP);
  assign active_o       = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_DESC_BASE: mem_addr_o = desc_q;
      ST_DESC_CNT:  mem_addr_o = desc_q + A_STEP;
      default:      mem_addr_o = addr_q;
    endcase
  end

  assign ack_ok    = mem_req_o && mem_ack_i && !mem_err_i;
  assign ack_bad   = mem_req_o && mem_ack_i && mem_err_i;
  assign fault_o   = ack_bad && !stop_i;
  assign done_o    = (state_q == ST_NEXT) && eot_q && !stop_i;
  assign last_word = (remain_q == C_STEP);
  assign cnt_in    = mem_rdata_i[CNT_W-1:0] & C_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      desc_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      data_q   <= '0;
      eot_q    <= 1'b0;
      dir_q    <= 1'b0;
    end else if (stop_i && state_q != ST_IDLE) begin
      state_q <= ST_IDLE;
    end else if (ack_bad) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          desc_q  <= tbl_ptr_i;
          dir_q   <= dir_i;
          state_q <= ST_DESC_BASE;
        end
        ST_DESC_BASE: if (ack_ok) begin
          addr_q  <= ADDR_W'(mem_rdata_i) & A_ALIGN;
          state_q <= ST_DESC_CNT;
        end
        ST_DESC_CNT: if (ack_ok) begin
          remain_q <= cnt_in;
          eot_q    <= mem_rdata_i[DESC_EOT];
          if (cnt_in == '0)  state_q <= ST_NEXT;
          else if (dir_q)    state_q <= ST_DEV_POP;
          else               state_q <= ST_MEM_RD;
        end
        ST_MEM_RD: if (ack_ok) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_DEV_PUSH;
        end
        ST_DEV_PUSH: if (dev_wr_ready_i) begin
          remain_q <= remain_q - C_STEP;
          addr_q   <= addr_q + A_STEP;
          state_q  <= last_word ? ST_NEXT : ST_MEM_RD;
        end
        ST_DEV_POP: if (dev_rd_valid_i) begin
          data_q  <= dev_rd_data_i;
          state_q <= ST_MEM_WR;
        end
        ST_MEM_WR: if (ack_ok) begin
          remain_q <= remain_q - C_STEP;
          addr_q   <= addr_q + A_STEP;
          state_q  <= last_word ? ST_NEXT : ST_DEV_POP;
        end
        ST_NEXT: begin
          if (eot_q) state_q <= ST_IDLE;
          else begin
            desc_q  <= desc_q + A_STRIDE;
            state_q <= ST_DESC_BASE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              dev_wr_valid_o,
  output logic [31:0]       dev_wr_data_o,
  input  logic              dev_wr_ready_i,
  input  logic              dev_rd_valid_i,
  input  logic [31:0]       dev_rd_data_i,
  output logic              dev_rd_ready_o
);
  logic              eng_go, eng_stop, eng_dir, eng_active, eng_done, eng_fault;
  logic              stat_err;
  logic [ADDR_W-1:0] tbl_ptr;

  bmdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .active_i    (eng_active),
    .done_i      (eng_done),
    .fault_i     (eng_fault),
    .go_o        (eng_go),
    .stop_o      (eng_stop),
    .dir_o       (eng_dir),
    .tbl_ptr_o   (tbl_ptr),
    .err_o       (stat_err),
    .irq_o       (irq_o)
  );

  bmdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .go_i           (eng_go),
    .stop_i         (eng_stop),
    .dir_i          (eng_dir),
    .tbl_ptr_i      (tbl_ptr),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_ack_i      (mem_ack_i),
    .mem_err_i      (mem_err_i),
    .mem_rdata_i    (mem_rdata_i),
    .dev_wr_valid_o (dev_wr_valid_o),
    .dev_wr_data_o  (dev_wr_data_o),
    .dev_wr_ready_i (dev_wr_ready_i),
    .dev_rd_valid_i (dev_rd_valid_i),
    .dev_rd_data_i  (dev_rd_data_i),
    .dev_rd_ready_o (dev_rd_ready_o),
    .active_o       (eng_active),
    .done_o         (eng_done),
    .fault_o        (eng_fault)
  );
endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              irq_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic              dev_wr_valid_o,
  input logic [31:0]       dev_wr_data_o,
  input logic              dev_wr_ready_i,
  input logic              dev_rd_ready_o,
  input logic              eng_active,
  input logic              stat_err
);
  logic stop_w;
  assign stop_w = reg_we_i && (reg_addr_i == 2'd0) && !reg_wdata_i[0];

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !stop_w) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_req_needs_active_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> eng_active);

  assert_fault_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i && !stop_w) |=>
      (stat_err && !eng_active && !mem_req_o));

  assert_irq_on_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (!eng_active && $past(eng_active)));

  assert_stop_idles_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !eng_active);

  assert_push_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_valid_o && !dev_wr_ready_i && !stop_w) |=>
      (dev_wr_valid_o && $stable(dev_wr_data_o)));

  assert_one_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_wr_valid_o && dev_rd_ready_o));
endmodule

bind bmdma_engine bmdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bmdma_engine_tb.sv
`timescale 1ns/1ps
module bmdma_engine_tb;
  localparam time TCK = 8ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        dev_wr_valid_o;
  logic [31:0] dev_wr_data_o;
  logic        dev_wr_ready_i = 1'b0;
  logic        dev_rd_valid_i;
  logic [31:0] dev_rd_data_i;
  logic        dev_rd_ready_o;

  bmdma_engine u_dut (.*);

  always #(TCK/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  bit          slow = 1'b0;
  logic [31:0] exp_dev[$];
  logic [31:0] exp_wa[$], exp_wd[$];
  logic [31:0] src [0:15];
  int          src_len = 0, src_start = 0, src_pops = 0;
  logic        prev_req = 1'b0, prev_ack = 1'b0, prev_we_reg = 1'b0;
  logic [31:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  assign dev_rd_valid_i = (src_pops - src_start) < src_len;
  assign dev_rd_data_i  = src[4'(src_pops - src_start)];

  // memory, device source and sink models
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    dev_wr_ready_i <= slow ? (cyc % 4 == 3) : (cyc % 2 == 0);
    if (dev_rd_valid_i && dev_rd_ready_o) src_pops <= src_pops + 1;
    mem_ack_i <= 1'b0;
    mem_err_i <= 1'b0;
    if (mem_req_o && !mem_ack_i && (cyc % 3 != 1)) begin
      mem_ack_i   <= 1'b1;
      mem_err_i   <= (mem_addr_o == err_addr);
      mem_rdata_i <= mem[mem_addr_o[9:2]];
      if (mem_we_o && mem_addr_o != err_addr) mem[mem_addr_o[9:2]] <= mem_wdata_o;
    end
  end

  // per-cycle comparison against the expected streams
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (dev_wr_valid_o && dev_wr_ready_i) begin
        if (exp_dev.size() == 0) chk(1'b0, "R4 unexpected device word", dev_wr_data_o, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_dev.pop_front();
          chk(dev_wr_data_o == e, "R4 device word order", dev_wr_data_o, e);
        end
      end
      if (mem_req_o && mem_we_o && mem_ack_i && !mem_err_i) begin
        if (exp_wa.size() == 0) chk(1'b0, "R5 unexpected memory write", mem_addr_o, 32'h0);
        else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(mem_addr_o == ea, "R5 write address", mem_addr_o, ea);
          chk(mem_wdata_o == ed, "R5 write data", mem_wdata_o, ed);
        end
      end
      if (prev_req && !prev_ack && !prev_we_reg && !(mem_req_o && mem_addr_o == prev_addr))
        chk(1'b0, "R13 request dropped or moved", mem_addr_o, prev_addr);
      prev_req    <= mem_req_o;
      prev_ack    <= mem_ack_i;
      prev_addr   <= mem_addr_o;
      prev_we_reg <= reg_we_i;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic put_desc(input int a, input logic [31:0] base, input logic [15:0] cnt, input bit eot);
    mem[a >> 2]       = base;
    mem[(a >> 2) + 1] = {eot, 15'd0, cnt};
  endtask

  task automatic wait_irq(input int n, input string req);
    for (int i = 0; i < n && !irq_o; i++) @(negedge clk_i);
    chk(irq_o, req, {31'd0, irq_o}, 32'd1);
  endtask

  task automatic load_m2d_table();
    put_desc(32'h100, 32'h200, 16'd8, 1'b0);
    put_desc(32'h108, 32'h301, 16'd14, 1'b1);   // low bits ignored: 3 words
    for (int i = 0; i < 2; i++) exp_dev.push_back(mem[(32'h200 >> 2) + i]);
    for (int i = 0; i < 3; i++) exp_dev.push_back(mem[(32'h300 >> 2) + i]);
  endtask

  initial begin
    logic [31:0] d;
    int q_before;
    bit quiet;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 17);
    for (int i = 0; i < 16; i++) src[i] = 32'h5A00_0000 + 32'(i * 3);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, d); chk(d == 0, "R1 command after reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 status after reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 pointer after reset", d, 0);
    chk(!irq_o && !mem_req_o && !dev_wr_valid_o && !dev_rd_ready_o, "R1 outputs idle",
        {irq_o, mem_req_o, dev_wr_valid_o, dev_rd_ready_o}, 0);

    // R2 pointer alignment
    wr(2'd2, 32'h0000_0123);
    rd(2'd2, d); chk(d == 32'h120, "R2 pointer low bits read zero", d, 32'h120);

    // R3 R4 R6 two-entry memory-to-device table
    load_m2d_table();
    wr(2'd2, 32'h100);
    wr(2'd1, 32'h6);
    wr(2'd0, 32'h1);
    rd(2'd1, d); chk(d[0], "R2 active while running", d, 1);
    wait_irq(600, "R6 completion interrupt");
    @(negedge clk_i);
    rd(2'd1, d); chk(d == 32'h4, "R6 status interrupt only", d, 32'h4);
    chk(exp_dev.size() == 0, "R3 all entries consumed", exp_dev.size(), 0);

    // R9 write-one-to-clear
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk(d == 32'h4, "R9 zero write keeps interrupt", d, 32'h4);
    wr(2'd1, 32'h4);
    rd(2'd1, d); chk(d == 32'h0, "R9 one write clears interrupt", d, 0);
    chk(!irq_o, "R6 irq_o follows status", irq_o, 0);

    // R5 device-to-memory
    put_desc(32'h140, 32'h380, 16'd16, 1'b1);
    for (int i = 0; i < 4; i++) begin
      exp_wa.push_back(32'h380 + 32'(4 * i));
      exp_wd.push_back(src[i]);
    end
    src_start = src_pops; src_len = 4;
    wr(2'd2, 32'h140);
    wr(2'd0, 32'h9);
    rd(2'd0, d); chk(d == 32'h9, "R2 command readback", d, 32'h9);
    wait_irq(600, "R5 completion");
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      chk(mem[(32'h380 >> 2) + i] == src[i], "R5 buffer contents", mem[(32'h380 >> 2) + i], src[i]);
    end
    chk(exp_wa.size() == 0, "R5 all words written", exp_wa.size(), 0);
    src_len = 0;
    wr(2'd1, 32'h6);

    // R7 zero-count entries
    put_desc(32'h180, 32'h200, 16'd3, 1'b0);
    put_desc(32'h188, 32'h3C0, 16'd4, 1'b1);
    exp_dev.push_back(mem[32'h3C0 >> 2]);
    wr(2'd2, 32'h180);
    wr(2'd0, 32'h1);
    wait_irq(300, "R7 skip empty entry");
    @(negedge clk_i);
    chk(exp_dev.size() == 0, "R7 only nonempty entry moved", exp_dev.size(), 0);
    wr(2'd1, 32'h6);
    put_desc(32'h1C0, 32'h200, 16'd0, 1'b1);
    wr(2'd2, 32'h1C0);
    wr(2'd0, 32'h1);
    wait_irq(100, "R7 empty end entry completes");
    @(negedge clk_i);
    rd(2'd1, d); chk(d == 32'h4, "R7 status after empty table", d, 32'h4);

    // R10 capability bits
    wr(2'd1, 32'h66);
    rd(2'd1, d); chk(d == 32'h60, "R10 capability readback", d, 32'h60);
    load_m2d_table();
    wr(2'd2, 32'h100);
    wr(2'd0, 32'h1);
    wait_irq(600, "R10 transfer with capability set");
    @(negedge clk_i);
    rd(2'd1, d); chk(d == 32'h64, "R10 status unaffected", d, 32'h64);
    chk(exp_dev.size() == 0, "R10 data unaffected", exp_dev.size(), 0);

    // R8 error response on second data read
    wr(2'd1, 32'h06);
    exp_dev.push_back(mem[32'h200 >> 2]);
    err_addr = 32'h204;
    wr(2'd0, 32'h1);
    for (int i = 0; i < 300; i++) begin
      rd(2'd1, d);
      if (d[1]) break;
      @(negedge clk_i);
    end
    rd(2'd1, d); chk(d == 32'h2, "R8 status error only", d, 32'h2);
    quiet = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk_i); if (mem_req_o) quiet = 1'b0; end
    chk(quiet && !irq_o, "R8 no request after error", {mem_req_o, irq_o}, 0);
    chk(exp_dev.size() == 0, "R8 first word delivered", exp_dev.size(), 0);
    err_addr = 32'hFFFF_FFFF;
    wr(2'd1, 32'h2);
    rd(2'd1, d); chk(d == 32'h0, "R9 error cleared", d, 0);

    // R11 stop mid transfer
    slow = 1'b1;
    put_desc(32'h1E0, 32'h000, 16'd64, 1'b1);
    for (int i = 0; i < 16; i++) exp_dev.push_back(mem[i]);
    wr(2'd2, 32'h1E0);
    wr(2'd0, 32'h1);
    repeat (14) @(negedge clk_i);
    wr(2'd0, 32'h0);
    rd(2'd1, d); chk(d == 32'h0, "R11 idle after stop", d, 0);
    q_before = exp_dev.size();
    chk(q_before > 0 && q_before < 16, "R11 stopped partway", q_before, 8);
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (mem_req_o || dev_wr_valid_o) quiet = 1'b0;
    end
    chk(quiet && exp_dev.size() == q_before, "R11 no activity after stop", exp_dev.size(), q_before);
    exp_dev.delete();

    // R12 start while active
    load_m2d_table();
    wr(2'd2, 32'h100);
    wr(2'd0, 32'h1);
    repeat (6) @(negedge clk_i);
    wr(2'd0, 32'h9);
    rd(2'd0, d); chk(d == 32'h1, "R12 command unchanged", d, 32'h1);
    wait_irq(800, "R12 transfer continues");
    @(negedge clk_i);
    rd(2'd1, d); chk(d == 32'h4, "R12 status", d, 32'h4);
    chk(exp_dev.size() == 0, "R12 direction kept", exp_dev.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule